// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes two byte operands and an operation code, and returns a byte result. It also returns the value of each status flag and a write mask that marks which flags the operation defines. The status register sits inside the block. Its carry bit is the carry input for the carry-chained operations. On each enabled cycle only the masked flags take new values and every other flag keeps its old value.

Arithmetic and negate share one add/subtract datapath. Increment, decrement and the word operations also use it. The logic operations and one's complement go through a separate bitwise unit. The word add and subtract of a 6-bit immediate take two enabled cycles. In the first cycle the low byte of the register pair is on `a_i` and the immediate is on `b_i[5:0]`. In the second cycle the high byte is on `a_i`, with the same operation code. The carry and the zero state of the low half are held between the two cycles.

Top module: `alu8_core`

## Requirements
- R1: Flag bits of `flags_o`, `flag_val_o` and `flag_wr_o` are C=0, Z=1, N=2, V=3, S=4, H=5. Add (op 0) gives a+b, and add-with-carry (op 1) gives a+b+C. Both write mask 6'b101111. C is the carry out of bit 7, H is the carry out of bit 3, V is the signed overflow, N is bit 7 of the result and Z is set when the result is zero.
- R2: Subtract (op 2) gives a-b, and subtract-with-carry (op 3) gives a-b-C. Both write mask 6'b101111. C is the borrow out of bit 7, H is the borrow into bit 4 from the low nibble, and V is the signed overflow.
- R3: For subtract-with-carry, Z is 1 only when the result is zero and Z was already 1.
- R4: AND (op 4), OR (op 5) and XOR (op 6) write mask 6'b001110 with V forced to 0. C, S and H keep their values.
- R5: One's complement (op 7) gives the bitwise inverse of a. It writes mask 6'b001111 with C forced to 1 and V forced to 0. H keeps its value.
- R6: Negate (op 8) gives 0-a and writes mask 6'b101111. C=1 when a is not 0, H=1 when a[3:0] is not 0, and V=1 only when a is 0x80.
- R7: Increment (op 9) gives a+1 and decrement (op 10) gives a-1. Both write mask 6'b001110. V=1 only for a=0x7F on increment and for a=0x80 on decrement. C keeps its value.
- R8: Word add (op 11) and word subtract (op 12) of the immediate b[5:0] take two enabled cycles. The first cycle returns the low result byte and writes no flags. The second cycle returns the high byte and writes mask 6'b011111. The flags are computed on the 16-bit value: C is the 16-bit carry or borrow, V is the 16-bit signed overflow, N is bit 15, and Z is set only if all 16 result bits are zero.
- R9: Whenever S is written it equals N XOR V.
- R10: With `en_i` low, `flags_o` does not change and a pending word operation does not advance. The result, the flag values and the mask are still produced.
- R11: After reset `flags_o` is 0 and no word operation is pending.
- R12: Operation codes 13 to 15 return result 0 and write no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Commit the flags and advance the word phase this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand, or the pair byte for word operations |
| b_i | input | 8 | Second operand; bits 5:0 are the immediate for word operations |
| res_o | output | 8 | Result byte |
| flag_val_o | output | 6 | Flag values from this operation (valid where the mask is 1) |
| flag_wr_o | output | 6 | Mask of the flags this operation writes |
| flags_o | output | 6 | Registered status flags |

## Verification
The bench targets the flags that must survive an operation. It checks that C survives the logic operations and increment or decrement, and that H survives one's complement. A design that writes the whole flag set would lose the carry that a multi-byte chain depends on. The bench also covers the sticky zero of subtract-with-carry with every combination of the prior Z and C. A design that takes Z from the low byte alone would report a 16-bit difference as zero while its upper byte is still non-zero. The word tests cross the low-byte carry and borrow into the high byte. They use the edge values 0x7F/0x80 and an all-zero pair. A missing held carry or a wrong 16-bit Z shows up there as a wrong high byte or a wrong flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W  = 4;
  localparam int NFLAG = 6;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;

  // logic ops share op[3:2]=01; op[1:0] selects the bitwise function
  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_WADD = 4'd11,
    OP_WSUB = 4'd12
  } alu_op_e;

  localparam logic [NFLAG-1:0] M_ARITH = 6'b101111;
  localparam logic [NFLAG-1:0] M_LOGIC = 6'b001110;
  localparam logic [NFLAG-1:0] M_COM   = 6'b001111;
  localparam logic [NFLAG-1:0] M_WORD  = 6'b011111;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o,
  output logic         co_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int NIB = 4;

  logic [W-1:0] bx;
  logic         cx;
  logic [W:0]   sum;
  logic [NIB:0] nib;

  // subtract as a + ~b + ~borrow_in; carries inverted back to borrows
  assign bx  = sub_i ? ~b_i : b_i;
  assign cx  = ci_i ^ sub_i;
  assign sum = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cx};
  assign nib = {1'b0, a_i[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cx};

  assign r_o  = sum[W-1:0];
  assign co_o = sum[W] ^ sub_i;
  assign h_o  = nib[NIB] ^ sub_i;
  assign v_o  = (a_i[W-1] == bx[W-1]) && (r_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] r_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   r_o = a_i & b_i;
      2'b01:   r_o = a_i | b_i;
      2'b10:   r_o = a_i ^ b_i;
      default: r_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[i] <= 1'b0;
      else if (we_i[i]) q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NFLAG-1:0]  flag_val_o,
  output logic [NFLAG-1:0]  flag_wr_o,
  output logic [NFLAG-1:0]  flags_o
);
  localparam int MSB = DATA_W - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DATA_W-1:0] ad_a, ad_b, ad_r, lg_r, res;
  logic              ad_ci, ad_sub, ad_co, ad_h, ad_v;
  logic [NFLAG-1:0]  val, mask, fq;
  logic              z_gate, is_word;
  logic              phase_q, wc_q, lz_q;

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .a_i(ad_a), .b_i(ad_b), .ci_i(ad_ci), .sub_i(ad_sub),
    .r_o(ad_r), .co_o(ad_co), .h_o(ad_h), .v_o(ad_v)
  );

  alu8_bitwise #(.W(DATA_W)) u_bitwise (
    .a_i(a_i), .b_i(b_i), .sel_i(op_i[1:0]), .r_o(lg_r)
  );

  assign is_word = (op == OP_WADD) || (op == OP_WSUB);

  always_comb begin
    ad_a   = a_i;
    ad_b   = b_i;
    ad_ci  = 1'b0;
    ad_sub = 1'b0;
    z_gate = 1'b1;
    mask   = '0;
    val    = '0;
    res    = ad_r;
    unique case (op)
      OP_ADD: mask = M_ARITH;
      OP_ADC: begin mask = M_ARITH; ad_ci = fq[F_C]; end
      OP_SUB: begin mask = M_ARITH; ad_sub = 1'b1; end
      OP_SBC: begin
        mask = M_ARITH; ad_sub = 1'b1; ad_ci = fq[F_C]; z_gate = fq[F_Z];
      end
      OP_AND, OP_OR, OP_XOR: begin mask = M_LOGIC; res = lg_r; end
      OP_COM: begin mask = M_COM; res = lg_r; end
      OP_NEG: begin
        mask = M_ARITH; ad_a = '0; ad_b = a_i; ad_sub = 1'b1;
      end
      OP_INC: begin mask = M_LOGIC; ad_b = DATA_W'(1); end
      OP_DEC: begin mask = M_LOGIC; ad_b = DATA_W'(1); ad_sub = 1'b1; end
      OP_WADD, OP_WSUB: begin
        ad_sub = (op == OP_WSUB);
        if (!phase_q) begin
          ad_b = {{(DATA_W-IMM_W){1'b0}}, b_i[IMM_W-1:0]};
        end else begin
          ad_b   = '0;
          ad_ci  = wc_q;
          z_gate = lz_q;
          mask   = M_WORD;
        end
      end
      default: res = '0;
    endcase
    val[F_C] = ad_co;
    val[F_H] = ad_h;
    val[F_V] = ad_v;
    if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_COM) begin
      val[F_V] = 1'b0;
      val[F_C] = 1'b1;
    end
    val[F_Z] = (res == '0) && z_gate;
    val[F_N] = res[MSB];
    val[F_S] = val[F_N] ^ val[F_V];
  end

  alu8_flag_reg #(.N(NFLAG)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(en_i ? mask : '0), .d_i(val), .q_o(fq)
  );

  // word phase: low half latches carry/borrow and zero state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      wc_q    <= 1'b0;
      lz_q    <= 1'b0;
    end else if (en_i) begin
      if (is_word && !phase_q) begin
        phase_q <= 1'b1;
        wc_q    <= ad_co;
        lz_q    <= (ad_r == '0);
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  assign res_o      = res;
  assign flag_val_o = val;
  assign flag_wr_o  = mask;
  assign flags_o    = fq;

  a_r4_logic_v_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_AND || op == OP_OR || op == OP_XOR) |-> (flag_wr_o[F_V] && !flag_val_o[F_V]));

  a_r5_com_c_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_COM) |-> (flag_val_o[F_C] && !flag_val_o[F_V] && !flag_wr_o[F_H]));

  a_r3_sbc_z_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SBC && !flags_o[F_Z]) |-> !flag_val_o[F_Z]);

  a_r7_incdec_c_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op == OP_INC || op == OP_DEC)) |=> (flags_o[F_C] == $past(flags_o[F_C])));

  a_r8_word_lo_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && is_word && !phase_q) |=> ($stable(flags_o) && phase_q));

  a_r8_word_hi_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && phase_q) |=> !phase_q);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(flags_o));

  a_r12_unused_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd12) |-> (flag_wr_o == '0 && res_o == '0));
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] res;
  logic [5:0] fval, fwr, flags;

  int total = 0;
  int bad   = 0;

  logic [5:0] m_flags = '0;
  logic       m_phase = 1'b0, m_wc = 1'b0, m_lz = 1'b0;

  always #5 clk = ~clk;

  alu8_core uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .a_i(a), .b_i(b),
    .res_o(res), .flag_val_o(fval), .flag_wr_o(fwr), .flags_o(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       output logic [7:0] r, output logic [5:0] v, output logic [5:0] m,
                       output logic nwc);
    int c, d;
    logic zg;
    c = int'(m_flags[0]); v = '0; m = '0; r = '0; nwc = 1'b0; zg = 1'b1;
    case (o)
      4'd0, 4'd1: begin
        if (o == 4'd0) c = 0;
        d = int'(x) + int'(y) + c; r = d[7:0];
        v[0] = d > 255;
        v[5] = (int'(x[3:0]) + int'(y[3:0]) + c) > 15;
        v[3] = (x[7] == y[7]) && (r[7] != x[7]);
        m = 6'b101111;
      end
      4'd2, 4'd3: begin
        if (o == 4'd2) c = 0; else zg = m_flags[1];
        d = int'(x) - int'(y) - c; r = d[7:0];
        v[0] = d < 0;
        v[5] = int'(x[3:0]) < (int'(y[3:0]) + c);
        v[3] = (x[7] != y[7]) && (r[7] != x[7]);
        m = 6'b101111;
      end
      4'd4: begin r = x & y; m = 6'b001110; end
      4'd5: begin r = x | y; m = 6'b001110; end
      4'd6: begin r = x ^ y; m = 6'b001110; end
      4'd7: begin r = ~x; v[0] = 1'b1; m = 6'b001111; end
      4'd8: begin
        r = 8'd0 - x; v[0] = x != 0; v[5] = x[3:0] != 0; v[3] = x == 8'h80;
        m = 6'b101111;
      end
      4'd9:  begin r = x + 8'd1; v[3] = x == 8'h7F; m = 6'b001110; end
      4'd10: begin r = x - 8'd1; v[3] = x == 8'h80; m = 6'b001110; end
      4'd11, 4'd12: begin
        if (!m_phase) begin
          if (o == 4'd11) d = int'(x) + int'(y[5:0]);
          else            d = int'(x) - int'(y[5:0]);
          r = d[7:0]; nwc = (d > 255) || (d < 0);
        end else begin
          if (o == 4'd11) begin
            r = x + 8'(m_wc); v[0] = x[7] & ~r[7]; v[3] = ~x[7] & r[7];
          end else begin
            r = x - 8'(m_wc); v[0] = ~x[7] & r[7]; v[3] = x[7] & ~r[7];
          end
          zg = m_lz; m = 6'b011111;
        end
      end
      default: r = '0;
    endcase
    v[1] = (r == 8'd0) && zg;
    v[2] = r[7];
    v[4] = v[2] ^ v[3];
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                      input logic e, input string tag);
    logic [7:0] r; logic [5:0] v, m; logic nwc;
    @(negedge clk);
    op = o; a = x; b = y; en = e;
    #1;
    model(o, x, y, r, v, m, nwc);
    chk({tag, " result"}, 32'(res), 32'(r));
    chk({tag, " mask"}, 32'(fwr), 32'(m));
    chk({tag, " flagval"}, 32'(fval & m), 32'(v & m));
    @(posedge clk);
    #1;
    if (e) begin
      m_flags = (m_flags & ~m) | (v & m);
      if ((o == 4'd11 || o == 4'd12) && !m_phase) begin
        m_phase = 1'b1; m_wc = nwc; m_lz = (r == 8'd0);
      end else m_phase = 1'b0;
    end
    chk({tag, " flags"}, 32'(flags), 32'(m_flags));
  endtask

  // preset C and Z through plain add/sub
  task automatic set_cz(input logic cv, input logic zv);
    if (cv && zv)  step(4'd0, 8'hFF, 8'h01, 1'b1, "preset");
    if (cv && !zv) step(4'd2, 8'h00, 8'h01, 1'b1, "preset");
    if (!cv && zv) step(4'd0, 8'h00, 8'h00, 1'b1, "preset");
    if (!cv && !zv) step(4'd0, 8'h01, 8'h00, 1'b1, "preset");
  endtask

  task automatic t_reset;
    chk("R11 flags in reset", 32'(flags), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 flags after reset", 32'(flags), 32'h0);
  endtask

  task automatic t_random(input logic [3:0] o, input string tag);
    for (int i = 0; i < 24; i++) begin
      set_cz(i[0], i[1]);
      step(o, 8'($urandom), 8'($urandom), 1'b1, tag);
    end
  endtask

  task automatic t_addsub_edges;
    set_cz(1'b1, 1'b0); step(4'd1, 8'h7F, 8'h00, 1'b1, "R1 adc overflow");
    step(4'd0, 8'h0F, 8'h01, 1'b1, "R1 add half carry");
    set_cz(1'b1, 1'b0); step(4'd3, 8'h10, 8'h00, 1'b1, "R2 sbc half borrow");
    step(4'd2, 8'h80, 8'h01, 1'b1, "R2 sub overflow");
  endtask

  task automatic t_sbc_z;
    set_cz(1'b0, 1'b0); step(4'd3, 8'h05, 8'h05, 1'b1, "R3 sbc z stays 0");
    set_cz(1'b0, 1'b1); step(4'd3, 8'h05, 8'h05, 1'b1, "R3 sbc z stays 1");
    set_cz(1'b1, 1'b1); step(4'd3, 8'h06, 8'h05, 1'b1, "R3 sbc z with carry");
    set_cz(1'b1, 1'b1); step(4'd3, 8'h06, 8'h06, 1'b1, "R3 sbc nonzero clears z");
  endtask

  task automatic t_logic_keep;
    step(4'd0, 8'h08, 8'h08, 1'b1, "preset h");
    set_cz(1'b1, 1'b0);
    step(4'd8, 8'h01, 8'h00, 1'b1, "R6 neg sets h");
    step(4'd4, 8'hF0, 8'h0F, 1'b1, "R4 and keeps c h");
    step(4'd5, 8'h80, 8'h01, 1'b1, "R4 or");
    step(4'd6, 8'hAA, 8'hAA, 1'b1, "R4 xor zero");
    step(4'd7, 8'hFF, 8'h00, 1'b1, "R5 com keeps h");
    set_cz(1'b0, 1'b0);
    step(4'd7, 8'h00, 8'h00, 1'b1, "R5 com sets c");
  endtask

  task automatic t_neg_incdec;
    step(4'd8, 8'h80, 8'h00, 1'b1, "R6 neg 0x80");
    step(4'd8, 8'h00, 8'h00, 1'b1, "R6 neg zero");
    set_cz(1'b1, 1'b0);
    step(4'd9, 8'h7F, 8'h00, 1'b1, "R7 inc overflow");
    step(4'd9, 8'hFF, 8'h00, 1'b1, "R7 inc wrap keeps c");
    set_cz(1'b0, 1'b0);
    step(4'd10, 8'h80, 8'h00, 1'b1, "R7 dec overflow");
    step(4'd10, 8'h00, 8'h00, 1'b1, "R7 dec wrap keeps c");
  endtask

  task automatic word(input logic [3:0] o, input logic [15:0] pair, input logic [5:0] k,
                      input string tag);
    step(o, pair[7:0], {2'b00, k}, 1'b1, {tag, " low"});
    step(o, pair[15:8], 8'h00, 1'b1, {tag, " high"});
    chk({tag, " R9 s=n^v"}, 32'(flags[4]), 32'(flags[2] ^ flags[3]));
  endtask

  task automatic t_word;
    set_cz(1'b1, 1'b1);
    word(4'd11, 16'h7FFF, 6'd1, "R8 wadd overflow");
    word(4'd12, 16'h0000, 6'd1, "R8 wsub borrow");
    word(4'd12, 16'h0001, 6'd1, "R8 wsub zero");
    word(4'd11, 16'hFFC1, 6'd63, "R8 wadd carry out");
    word(4'd12, 16'h8000, 6'd1, "R8 wsub overflow");
    word(4'd11, 16'h0100, 6'd0, "R8 wadd hi nonzero");
    for (int i = 0; i < 20; i++)
      word(i[0] ? 4'd12 : 4'd11, 16'($urandom), 6'($urandom), "R8 word random");
  endtask

  task automatic t_hold;
    set_cz(1'b1, 1'b0);
    step(4'd0, 8'h00, 8'h00, 1'b0, "R10 add disabled");
    step(4'd7, 8'h12, 8'h00, 1'b0, "R10 com disabled");
    step(4'd11, 8'hFF, 8'h01, 1'b0, "R10 word disabled");
    step(4'd11, 8'hFF, 8'h01, 1'b0, "R10 word still low");
    word(4'd11, 16'h12FF, 6'd1, "R10 word after idle");
  endtask

  task automatic t_unused;
    set_cz(1'b1, 1'b1);
    for (int k = 13; k < 16; k++)
      step(4'(k), 8'hA5, 8'h5A, 1'b1, "R12 unused op");
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_random(4'd0, "R1 add rand");
    t_random(4'd1, "R1 adc rand");
    t_random(4'd2, "R2 sub rand");
    t_random(4'd3, "R2 R3 sbc rand");
    t_random(4'd4, "R4 and rand");
    t_random(4'd5, "R4 or rand");
    t_random(4'd6, "R4 xor rand");
    t_random(4'd7, "R5 com rand");
    t_random(4'd8, "R6 neg rand");
    t_random(4'd9, "R7 inc rand");
    t_random(4'd10, "R7 dec rand");
    t_addsub_edges();
    t_sbc_z();
    t_logic_keep();
    t_neg_incdec();
    t_word();
    t_hold();
    t_unused();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule